// File: doc/BRIEF.md
# Read Response Bus Agent

This block sits on the memory side of a multiplexed processor system bus and answers read requests. It latches one outstanding request, either a single word or a block of four or eight words. The processor gives up the bus on its own after it issues the request. The block then waits one turnaround cycle and drives a run of data cycles onto the shared address/data bus and the command bus, with the output-enable set for the whole run.

Each data cycle carries a three-bit command identifier. The identifier marks the word as response data, flags the final word, and passes on the error flag that the local memory port supplies with that word. Words come from the memory port through a valid/ready handshake. When no word is available, the block fills the gap with idle cycles and keeps the buses driven. An erroneous word does not cut the response short. After the last word the block releases both buses, pulses `done` and clears the pending request.

Top module: `rdresp_agent`

## Requirements
- R1: After reset and whenever the agent is not transferring, `bus_oe`, `bus_cmd`, `bus_ad`, `done` and `mem_ready` are all 0.
- R2: A request pulse on `req_valid` is latched only when no request is pending. A pulse that arrives while one is held is ignored, so the response keeps the first request's length.
- R3: If `own_grant` is high while no request is pending, nothing is driven: `bus_oe` and `mem_ready` stay 0.
- R4: When `own_grant` is sampled high with a request pending at edge k, `mem_ready` rises after edge k+1 and the earliest `bus_oe` is after edge k+2. This gives one full turnaround cycle.
- R5: The response length is 1 data cycle when `req_block`=0. When `req_block`=1 it is 4 data cycles with `req_long`=0 and 8 data cycles with `req_long`=1.
- R6: The identifier bits of a data cycle are: bit0=1 (response data), bit1=1 only on the final data cycle, and bit2 equal to the `mem_err` of that word.
- R7: If `mem_valid` is low while `mem_ready` is high, the next bus cycle is an idle cycle with `bus_oe`=1, `bus_cmd`=3'b000 and `bus_ad`=0.
- R8: Words flagged with `mem_err` still count, and the full number of data cycles from R5 is always sent.
- R9: `done` is high for exactly the cycle that shows the final data cycle. In the following cycle `bus_oe` is 0, `bus_cmd` is 0 and `mem_ready` is 0.
- R10: Data cycles carry the accepted memory words in acceptance order, one word per data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle pulse capturing a processor read request |
| req_block | input | 1 | 0 = single word, 1 = block read |
| req_long | input | 1 | Block size select: 0 = 4 words, 1 = 8 words |
| own_grant | input | 1 | High while the processor has moved itself to the listening state |
| mem_valid | input | 1 | Memory word available |
| mem_data | input | DATA_W | Memory word |
| mem_err | input | 1 | Memory word is erroneous |
| mem_ready | output | 1 | Agent takes a memory word this cycle |
| bus_ad | output | DATA_W | Address/data bus value |
| bus_cmd | output | 3 | Command identifier {error, last, response} |
| bus_oe | output | 1 | Drive enable for both buses (0 = high impedance) |
| done | output | 1 | One-cycle pulse with the final data cycle |

## Verification
The assertions take it as given that `own_grant` stays high from the hand-over until `done`. They also take it as given that a request is issued only when the processor is actually waiting for one. They do not check the memory side beyond the handshake. The bench keeps to these conditions: it raises `own_grant` only after a request has been captured, and holds it until it sees `done`. The one exception is a deliberate grant with nothing pending. Memory words are offered only while the bench observes `mem_ready` high.

// File: rtl/rdresp_pkg.sv
package rdresp_pkg;
  localparam int CMD_W    = 3;
  localparam int CMD_RESP = 0;
  localparam int CMD_LAST = 1;
  localparam int CMD_ERR  = 2;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_TURN = 2'd1,
    S_XFER = 2'd2
  } seq_st_e;
endpackage

// File: rtl/rdresp_hold.sv
// Holds one outstanding read request and its response length.
module rdresp_hold #(
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 8,
  parameter int LEN_W     = $clog2(LONG_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_block,
  input  logic             req_long,
  input  logic             clear,
  output logic             pending,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] L_WORD  = LEN_W'(1);
  localparam logic [LEN_W-1:0] L_SHORT = LEN_W'(SHORT_LEN);
  localparam logic [LEN_W-1:0] L_LONG  = LEN_W'(LONG_LEN);

  logic [LEN_W-1:0] len_sel;

  always_comb begin
    if (!req_block)     len_sel = L_WORD;
    else if (req_long)  len_sel = L_LONG;
    else                len_sel = L_SHORT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      len     <= L_WORD;
    end else if (clear) begin
      pending <= 1'b0;
    end else if (req_valid && !pending) begin
      pending <= 1'b1;
      len     <= len_sel;
    end
  end
endmodule

// File: rtl/rdresp_seq.sv
// Ownership wait, turnaround and beat counting.
module rdresp_seq
  import rdresp_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic [LEN_W-1:0] len,
  input  logic             own_grant,
  input  logic             mem_valid,
  output logic             xfer,
  output logic             fire,
  output logic             last_fire
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seq_st_e          st_q;
  logic [LEN_W-1:0] beat_q;

  assign xfer      = (st_q == S_XFER);
  assign fire      = xfer && mem_valid;
  assign last_fire = fire && (beat_q == len - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      beat_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          beat_q <= '0;
          if (pending && own_grant) st_q <= S_TURN;
        end
        S_TURN: st_q <= S_XFER;
        S_XFER: begin
          if (last_fire) begin
            st_q   <= S_IDLE;
            beat_q <= '0;
          end else if (fire) begin
            beat_q <= beat_q + ONE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdresp_drive.sv
// Registered bus outputs and completion strobe.
module rdresp_drive
  import rdresp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer,
  input  logic              fire,
  input  logic              last_fire,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              mem_err,
  output logic [DATA_W-1:0] bus_ad,
  output logic [CMD_W-1:0]  bus_cmd,
  output logic              bus_oe,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ad  <= '0;
      bus_cmd <= '0;
      bus_oe  <= 1'b0;
      done    <= 1'b0;
    end else begin
      bus_oe <= xfer;
      done   <= last_fire;
      if (fire) begin
        bus_ad            <= mem_data;
        bus_cmd[CMD_RESP] <= 1'b1;
        bus_cmd[CMD_LAST] <= last_fire;
        bus_cmd[CMD_ERR]  <= mem_err;
      end else begin
        bus_ad  <= '0;
        bus_cmd <= '0;
      end
    end
  end
endmodule

// File: rtl/rdresp_agent.sv
module rdresp_agent
  import rdresp_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_block,
  input  logic              req_long,
  input  logic              own_grant,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              mem_err,
  output logic              mem_ready,
  output logic [DATA_W-1:0] bus_ad,
  output logic [2:0]        bus_cmd,
  output logic              bus_oe,
  output logic              done
);
  localparam int LEN_W = $clog2(LONG_LEN + 1);

  logic             pending;
  logic [LEN_W-1:0] req_len;
  logic             xfer, fire, last_fire;

  rdresp_hold #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .LEN_W(LEN_W)) u_hold (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_block(req_block),
    .req_long(req_long), .clear(last_fire), .pending(pending), .len(req_len)
  );

  rdresp_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .pending(pending), .len(req_len),
    .own_grant(own_grant), .mem_valid(mem_valid), .xfer(xfer),
    .fire(fire), .last_fire(last_fire)
  );

  rdresp_drive #(.DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst(rst), .xfer(xfer), .fire(fire), .last_fire(last_fire),
    .mem_data(mem_data), .mem_err(mem_err), .bus_ad(bus_ad),
    .bus_cmd(bus_cmd), .bus_oe(bus_oe), .done(done)
  );

  assign mem_ready = xfer;
endmodule

// File: rtl/rdresp_agent_chk.sv
module rdresp_agent_chk #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              own_grant,
  input logic              mem_ready,
  input logic [DATA_W-1:0] bus_ad,
  input logic [2:0]        bus_cmd,
  input logic              bus_oe,
  input logic              done,
  input logic              pending,
  input logic [LEN_W-1:0]  len
);
  logic [LEN_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || done)                 seen_q <= '0;
    else if (bus_oe && bus_cmd[0])   seen_q <= seen_q + LEN_W'(1);
  end

  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_cmd == 3'b000 && bus_ad == '0));

  assert_needs_pending_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(pending));

  assert_ready_under_grant_R4: assert property (@(posedge clk) disable iff (rst)
    mem_ready |-> own_grant);

  assert_last_is_resp_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && bus_cmd[1]) |-> bus_cmd[0]);

  assert_full_length_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (seen_q + LEN_W'(1) == len));

  assert_done_on_last_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (bus_oe && bus_cmd[1]));

  assert_release_after_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> (!bus_oe && !mem_ready));
endmodule

bind rdresp_agent rdresp_agent_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .own_grant(own_grant), .mem_ready(mem_ready),
  .bus_ad(bus_ad), .bus_cmd(bus_cmd), .bus_oe(bus_oe), .done(done),
  .pending(pending), .len(req_len)
);

// File: tb/tb_rdresp_agent.sv
`timescale 1ns/1ps
module tb_rdresp_agent;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_block, req_long, own_grant;
  logic          mem_valid, mem_err;
  logic [DW-1:0] mem_data;
  logic          mem_ready, bus_oe, done;
  logic [DW-1:0] bus_ad;
  logic [2:0]    bus_cmd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  rdresp_agent #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_block(req_block),
    .req_long(req_long), .own_grant(own_grant), .mem_valid(mem_valid),
    .mem_data(mem_data), .mem_err(mem_err), .mem_ready(mem_ready),
    .bus_ad(bus_ad), .bus_cmd(bus_cmd), .bus_oe(bus_oe), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(bus_oe == 1'b0, {req, " oe"}, 64'(bus_oe), 64'd0);
    chk(bus_cmd == 3'b000, {req, " cmd"}, 64'(bus_cmd), 64'd0);
    chk(bus_ad == '0, {req, " ad"}, bus_ad, 64'd0);
    chk(mem_ready == 1'b0, {req, " ready"}, 64'(mem_ready), 64'd0);
    chk(done == 1'b0, {req, " done"}, 64'(done), 64'd0);
  endtask

  // R1 reset state
  task automatic t_reset();
    rst = 1; req_valid = 0; req_block = 0; req_long = 0; own_grant = 0;
    mem_valid = 0; mem_err = 0; mem_data = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_idle("R1 reset");
  endtask

  // R3 grant with nothing pending
  task automatic t_idle_grant();
    own_grant = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(bus_oe == 0 && mem_ready == 0, "R3 no drive without request",
          64'({bus_oe, mem_ready}), 64'd0);
    end
    own_grant = 0;
    @(negedge clk);
  endtask

  // Full response: R2 R4 R5 R6 R7 R8 R9 R10
  task automatic run_resp(input bit blk, input bit lng, input logic [7:0] errm,
                          input logic [15:0] stallm, input bit dup,
                          input logic [7:0] tag);
    int n = blk ? (lng ? 8 : 4) : 1;
    int beat = 0;
    req_valid = 1; req_block = blk; req_long = lng;
    @(negedge clk);
    req_valid = 0;
    if (dup) begin
      req_valid = 1; req_block = !blk; req_long = !lng;
      @(negedge clk);
      req_valid = 0;
    end
    @(negedge clk);
    chk_idle("R1 pending before grant");
    own_grant = 1;
    @(negedge clk);
    chk(mem_ready == 0 && bus_oe == 0, "R4 turnaround cycle",
        64'({mem_ready, bus_oe}), 64'd0);
    @(negedge clk);
    chk(mem_ready == 1, "R4 ready after turnaround", 64'(mem_ready), 64'd1);
    chk(bus_oe == 0, "R4 oe not yet", 64'(bus_oe), 64'd0);
    for (int c = 0; c < 40 && beat < n; c++) begin
      logic sent;
      logic [DW-1:0] wd;
      logic we;
      sent = (c < 16) ? !stallm[c] : 1'b1;
      wd = {tag, 48'h0, 8'(beat)};
      we = errm[beat];
      chk(mem_ready == 1, "R8 ready held until complete", 64'(mem_ready), 64'd1);
      mem_valid = sent; mem_data = wd; mem_err = we;
      @(negedge clk);
      chk(bus_oe == 1, "R7 oe during transfer", 64'(bus_oe), 64'd1);
      if (sent) begin
        logic [2:0] ec;
        ec = {we, (beat == n - 1), 1'b1};
        chk(bus_cmd == ec, "R6 identifier", 64'(bus_cmd), 64'(ec));
        chk(bus_ad == wd, "R10 data order", bus_ad, wd);
        beat++;
      end else begin
        chk(bus_cmd == 3'b000 && bus_ad == '0, "R7 idle cycle",
            64'(bus_cmd), 64'd0);
      end
      chk(done == (beat == n && sent), "R9 done timing", 64'(done),
          64'(beat == n && sent));
    end
    chk(beat == n, "R5 R8 response length", 64'(beat), 64'(n));
    mem_valid = 0; mem_err = 0; mem_data = '0;
    @(negedge clk);
    chk_idle("R9 release");
    own_grant = 0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    run_resp(0, 0, 8'h00, 16'h0000, 0, 8'h11);   // R5 word
    run_resp(1, 0, 8'h04, 16'h0000, 0, 8'h22);   // R5 block 4, R8 error mid
    run_resp(1, 1, 8'h81, 16'h0125, 0, 8'h33);   // R7 stalls, R8 errors
    t_idle_grant();                              // R3
    run_resp(1, 0, 8'h00, 16'h0000, 1, 8'h44);   // R2 ignored second request
    run_resp(0, 1, 8'h01, 16'h0003, 1, 8'h55);   // R2 word, R6 error, R7 stall
    run_resp(1, 1, 8'hFF, 16'h0000, 0, 8'h66);   // R8 all erroneous
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule